// File: doc/BRIEF.md
# MII Management Auto-Poll Scheduler

This block paces the automatic status reads that a management controller issues to an external PHY over the two-wire MII management bus. While automatic polling is enabled, it raises a poll request toward a separate MDIO frame engine. Once that engine accepts the request and later reports that the frame has finished, the scheduler waits a programmable number of management-clock (MDC) rising edges and then raises the next request. The MDC edges reach the block as a one-cycle tick.

The wait comes from a 3-bit dwell code that can be written and read back at any time. Code zero polls back to back. Codes one to five select 128, 256, 512, 1024 or 2048 MDC edges. The two remaining codes are reserved and fall back to the slowest interval. A hard reset loads the 1024-edge code. A soft reset abandons any wait or pending request but keeps the programmed code.

Top module: `apoll_sched`

## Requirements
- R1: After hard reset (`hrst_n` low, asynchronous), `dwell_code` reads 3'b100 and `poll_req` is low.
- R2: With dwell code 3'b000, `poll_req` is high in the cycle right after the cycle in which `frame_done` is sampled, with no MDC tick needed.
- R3: With dwell codes 3'b001, 3'b010, 3'b011, 3'b100 and 3'b101, `poll_req` rises in the cycle after the 128th, 256th, 512th, 1024th or 2048th `mdc_tick` counted from the cycle after `frame_done`. It stays low before that tick.
- R4: Reserved codes 3'b110 and 3'b111 produce the same 2048-tick wait as 3'b101.
- R5: A `srst` pulse leaves `dwell_code` unchanged and forces `poll_req` low in the next cycle. It also discards any running wait. Polling then restarts as in R10.
- R6: While `poll_en` is low, `poll_req` is low from the next cycle on, whatever `mdc_tick` and `frame_done` do. Dropping `poll_en` withdraws a pending request.
- R7: `poll_req` stays high until `poll_ack` is sampled high and is low in the following cycle. After an accept, no new request is raised until `frame_done` arrives, so at most one request is outstanding.
- R8: The dwell code is sampled when `frame_done` ends a frame. A write during a running wait does not change that wait. It applies from the next frame end.
- R9: A write (`dwell_we` high) loads `dwell_wdata` into `dwell_code`, which reads the new value in the next cycle. Writes are accepted in every state.
- R10: When `poll_en` is high and the scheduler is idle (after reset, soft reset or re-enable), `poll_req` is high in the cycle after `poll_en` is first sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| hrst_n | input | 1 | Hard reset, asynchronous, active low |
| srst | input | 1 | Soft reset strobe, synchronous, one cycle |
| dwell_we | input | 1 | Dwell code write enable |
| dwell_wdata | input | 3 | Dwell code write value |
| dwell_code | output | 3 | Current dwell code (readback) |
| poll_en | input | 1 | Automatic polling enable |
| mdc_tick | input | 1 | One-cycle pulse per MDC rising edge |
| poll_ack | input | 1 | Frame engine accepts the pending request |
| frame_done | input | 1 | Frame engine has finished the management frame |
| poll_req | output | 1 | Poll request to the frame engine |

## Verification
The bench counts the exact number of MDC ticks between the end of a frame and the next request for every dwell code. An off-by-one counter shows up as 127 or 129 ticks, and a wrong decode table shows up as a wrong power of two. Reserved codes are run to catch a decode that wraps them to a short or continuous interval. A dwell write in the middle of a wait targets a design that reloads its counter from the live code: such a design would shorten or stretch the wait in progress. Soft reset, withdrawal by disabling, and holding a request without an accept are each driven to expose three faults: a design that wipes the code on soft reset, one that keeps requesting while disabled, and one that raises a second request during a frame.

// File: rtl/apoll_pkg.sv
`timescale 1ns/1ps
package apoll_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_REQ  = 2'd1,
    SQ_BUSY = 2'd2,
    SQ_WAIT = 2'd3
  } sq_state_e;

  // Wait length in MDC edges for a dwell code; codes above max_code are clamped.
  function automatic int unsigned dwell_cycles(input int unsigned code,
                                               input int unsigned base_shift,
                                               input int unsigned max_code);
    int unsigned c;
    c = (code > max_code) ? max_code : code;
    if (c == 0) return 0;
    return 32'd1 << (base_shift + c - 1);
  endfunction

endpackage

// File: rtl/apoll_dwell_reg.sv
`timescale 1ns/1ps
module apoll_dwell_reg #(
  parameter int unsigned CODE_W     = 3,
  parameter int unsigned RESET_CODE = 4
) (
  input  logic              clk,
  input  logic              hrst_n,
  input  logic              we,
  input  logic [CODE_W-1:0] wdata,
  output logic [CODE_W-1:0] code
);
  // Only hard reset touches the code; soft reset is deliberately not an input.
  always_ff @(posedge clk or negedge hrst_n) begin
    if (!hrst_n)  code <= CODE_W'(RESET_CODE);
    else if (we)  code <= wdata;
  end
endmodule

// File: rtl/apoll_interval_ctr.sv
`timescale 1ns/1ps
module apoll_interval_ctr #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk,
  input  logic             hrst_n,
  input  logic             srst,
  input  logic             start,
  input  logic [CNT_W-1:0] limit,
  input  logic             run,
  input  logic             tick,
  output logic             expire
);
  logic [CNT_W-1:0] remain;

  assign expire = run && tick && (remain == CNT_W'(1));

  always_ff @(posedge clk or negedge hrst_n) begin
    if (!hrst_n)                             remain <= '0;
    else if (srst)                           remain <= '0;
    else if (start)                          remain <= limit;
    else if (run && tick && remain != '0)    remain <= remain - CNT_W'(1);
  end
endmodule

// File: rtl/apoll_seq.sv
`timescale 1ns/1ps
module apoll_seq
  import apoll_pkg::*;
(
  input  logic clk,
  input  logic hrst_n,
  input  logic srst,
  input  logic poll_en,
  input  logic poll_ack,
  input  logic frame_done,
  input  logic cont_mode,
  input  logic expire,
  output logic poll_req,
  output logic busy,
  output logic waiting,
  output logic start
);
  sq_state_e state, state_nx;

  assign poll_req = (state == SQ_REQ);
  assign busy     = (state == SQ_BUSY);
  assign waiting  = (state == SQ_WAIT);
  assign start    = busy && frame_done && poll_en && !srst;

  always_comb begin
    state_nx = state;
    if (srst) begin
      state_nx = SQ_IDLE;
    end else if (!poll_en) begin
      state_nx = SQ_IDLE;
    end else begin
      unique case (state)
        SQ_IDLE: state_nx = SQ_REQ;
        SQ_REQ:  if (poll_ack)   state_nx = SQ_BUSY;
        SQ_BUSY: if (frame_done) state_nx = cont_mode ? SQ_REQ : SQ_WAIT;
        SQ_WAIT: if (expire)     state_nx = SQ_REQ;
        default: state_nx = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge hrst_n) begin
    if (!hrst_n) state <= SQ_IDLE;
    else         state <= state_nx;
  end
endmodule

// File: rtl/apoll_sched.sv
`timescale 1ns/1ps
module apoll_sched
  import apoll_pkg::*;
#(
  parameter int unsigned CODE_W     = 3,
  parameter int unsigned BASE_SHIFT = 7,
  parameter int unsigned MAX_CODE   = 5,
  parameter int unsigned RESET_CODE = 4
) (
  input  logic              clk,
  input  logic              hrst_n,
  input  logic              srst,
  input  logic              dwell_we,
  input  logic [CODE_W-1:0] dwell_wdata,
  output logic [CODE_W-1:0] dwell_code,
  input  logic              poll_en,
  input  logic              mdc_tick,
  input  logic              poll_ack,
  input  logic              frame_done,
  output logic              poll_req
);
  localparam int unsigned CNT_W = BASE_SHIFT + MAX_CODE;

  logic [CNT_W-1:0] dwell_limit;
  logic             cont_mode;
  logic             cnt_start;
  logic             wait_expire;
  logic             seq_busy;
  logic             seq_wait;

  assign dwell_limit = CNT_W'(dwell_cycles(int'(dwell_code), BASE_SHIFT, MAX_CODE));
  assign cont_mode   = (dwell_limit == '0);

  apoll_dwell_reg #(.CODE_W(CODE_W), .RESET_CODE(RESET_CODE)) u_dwell (
    .clk    (clk),
    .hrst_n (hrst_n),
    .we     (dwell_we),
    .wdata  (dwell_wdata),
    .code   (dwell_code)
  );

  apoll_interval_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk    (clk),
    .hrst_n (hrst_n),
    .srst   (srst),
    .start  (cnt_start),
    .limit  (dwell_limit),
    .run    (seq_wait),
    .tick   (mdc_tick),
    .expire (wait_expire)
  );

  apoll_seq u_seq (
    .clk        (clk),
    .hrst_n     (hrst_n),
    .srst       (srst),
    .poll_en    (poll_en),
    .poll_ack   (poll_ack),
    .frame_done (frame_done),
    .cont_mode  (cont_mode),
    .expire     (wait_expire),
    .poll_req   (poll_req),
    .busy       (seq_busy),
    .waiting    (seq_wait),
    .start      (cnt_start)
  );
endmodule

// File: rtl/apoll_sched_chk.sv
`timescale 1ns/1ps
module apoll_sched_chk #(
  parameter int unsigned CODE_W = 3
) (
  input logic              clk,
  input logic              hrst_n,
  input logic              srst,
  input logic              dwell_we,
  input logic [CODE_W-1:0] dwell_code,
  input logic              poll_en,
  input logic              mdc_tick,
  input logic              poll_ack,
  input logic              frame_done,
  input logic              poll_req,
  input logic              seq_busy,
  input logic              wait_expire
);
  AST_OFF_NO_REQ: assert property (@(posedge clk) disable iff (!hrst_n)
    !poll_en |=> !poll_req); // R6
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!hrst_n)
    poll_req && !poll_ack && poll_en && !srst |=> poll_req); // R7
  AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!hrst_n)
    poll_req && poll_ack |=> !poll_req); // R7
  AST_SRST_KEEPS_CODE: assert property (@(posedge clk) disable iff (!hrst_n)
    srst && !dwell_we |=> $stable(dwell_code)); // R5
  AST_SRST_DROPS_REQ: assert property (@(posedge clk) disable iff (!hrst_n)
    srst |=> !poll_req); // R5
  AST_CONT_POLL: assert property (@(posedge clk) disable iff (!hrst_n)
    seq_busy && frame_done && poll_en && !srst && dwell_code == '0 |=> poll_req); // R2
  AST_EXPIRE_ON_TICK: assert property (@(posedge clk) disable iff (!hrst_n)
    wait_expire |-> mdc_tick); // R3
  AST_NO_REQ_IN_FRAME: assert property (@(posedge clk) disable iff (!hrst_n)
    seq_busy && !frame_done |=> !poll_req); // R7
endmodule

bind apoll_sched apoll_sched_chk #(.CODE_W(CODE_W)) u_chk (
  .clk         (clk),
  .hrst_n      (hrst_n),
  .srst        (srst),
  .dwell_we    (dwell_we),
  .dwell_code  (dwell_code),
  .poll_en     (poll_en),
  .mdc_tick    (mdc_tick),
  .poll_ack    (poll_ack),
  .frame_done  (frame_done),
  .poll_req    (poll_req),
  .seq_busy    (seq_busy),
  .wait_expire (wait_expire)
);

// File: tb/test_apoll_sched.sv
`timescale 1ns/1ps
module test_apoll_sched;
  logic       clk = 1'b0;
  logic       hrst_n = 1'b1;
  logic       srst = 1'b0;
  logic       dwell_we = 1'b0;
  logic [2:0] dwell_wdata = 3'd0;
  logic [2:0] dwell_code;
  logic       poll_en = 1'b0;
  logic       mdc_tick = 1'b0;
  logic       poll_ack = 1'b0;
  logic       frame_done = 1'b0;
  logic       poll_req;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  apoll_sched i_apoll_sched (
    .clk(clk), .hrst_n(hrst_n), .srst(srst),
    .dwell_we(dwell_we), .dwell_wdata(dwell_wdata), .dwell_code(dwell_code),
    .poll_en(poll_en), .mdc_tick(mdc_tick), .poll_ack(poll_ack),
    .frame_done(frame_done), .poll_req(poll_req)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Expected wait per code, restated as a lookup.
  function automatic int exp_ticks(input int code);
    case (code)
      0: return 0;
      1: return 128;
      2: return 256;
      3: return 512;
      4: return 1024;
      default: return 2048;
    endcase
  endfunction

  task automatic set_code(input int c);
    @(negedge clk); dwell_we = 1'b1; dwell_wdata = 3'(c);
    @(negedge clk); dwell_we = 1'b0;
    chk("R9 dwell readback", int'(dwell_code), c);
  endtask

  // Accept the pending request, hold a frame, end it. Returns at the negedge after frame_done is sampled.
  task automatic run_frame();
    int req_seen_in_frame;
    @(negedge clk); poll_ack = 1'b1;
    @(negedge clk); poll_ack = 1'b0;
    req_seen_in_frame = int'(poll_req);
    for (int i = 0; i < 6; i++) begin
      mdc_tick = (i % 2 == 0);
      @(negedge clk);
      if (poll_req) req_seen_in_frame = 1;
    end
    mdc_tick = 1'b0;
    chk("R7 no request during frame", req_seen_in_frame, 0);
    frame_done = 1'b1;
    @(negedge clk); frame_done = 1'b0;
  endtask

  // Count ticks until poll_req; optional dwell write after mid_at ticks.
  task automatic measure(output int n, input int mid_at, input int mid_code);
    bit phase = 1'b0;
    int guard = 0;
    n = 0;
    while (!poll_req && guard < 10000) begin
      if (mid_at >= 0 && n == mid_at) begin dwell_we = 1'b1; dwell_wdata = 3'(mid_code); end
      else dwell_we = 1'b0;
      phase = !phase;
      mdc_tick = phase;
      if (phase) n++;
      guard++;
      @(negedge clk);
    end
    mdc_tick = 1'b0;
    dwell_we = 1'b0;
  endtask

  task automatic t_reset();
    #2 hrst_n = 1'b0;
    repeat (3) @(negedge clk);
    hrst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset dwell code", int'(dwell_code), 4);
    chk("R1 reset poll_req", int'(poll_req), 0);
  endtask

  task automatic t_disabled();
    int seen = 0;
    for (int i = 0; i < 40; i++) begin
      mdc_tick = (i % 2 == 0);
      frame_done = (i == 10);
      @(negedge clk);
      if (poll_req) seen = 1;
    end
    mdc_tick = 1'b0; frame_done = 1'b0;
    chk("R6 no request while disabled", seen, 0);
  endtask

  task automatic t_enable();
    poll_en = 1'b1;
    @(negedge clk);
    chk("R10 first request after enable", int'(poll_req), 1);
  endtask

  task automatic t_hold();
    int held = 1;
    for (int i = 0; i < 8; i++) begin
      mdc_tick = (i % 2 == 0);
      @(negedge clk);
      if (!poll_req) held = 0;
    end
    mdc_tick = 1'b0;
    chk("R7 request held without accept", held, 1);
    @(negedge clk); poll_ack = 1'b1;
    @(negedge clk); poll_ack = 1'b0;
    chk("R7 request drops after accept", int'(poll_req), 0);
    for (int i = 0; i < 4; i++) @(negedge clk);
    chk("R7 single outstanding", int'(poll_req), 0);
    frame_done = 1'b1;
    @(negedge clk); frame_done = 1'b0;
  endtask

  task automatic t_default_wait();
    int n;
    measure(n, -1, 0);
    chk("R3 default code 100 wait", n, 1024);
  endtask

  task automatic t_all_codes();
    int n;
    for (int c = 0; c < 8; c++) begin
      set_code(c);
      run_frame();
      measure(n, -1, 0);
      if (c == 0)      chk("R2 continuous polling", n, exp_ticks(c));
      else if (c <= 5) chk($sformatf("R3 code %0d wait", c), n, exp_ticks(c));
      else             chk($sformatf("R4 reserved code %0d wait", c), n, exp_ticks(c));
    end
  endtask

  task automatic t_write_mid();
    int n;
    set_code(1);
    run_frame();
    measure(n, 10, 2);
    chk("R8 write mid-wait keeps current wait", n, 128);
    chk("R9 mid-wait write visible", int'(dwell_code), 2);
    run_frame();
    measure(n, -1, 0);
    chk("R8 written code applies at next frame end", n, 256);
  endtask

  task automatic t_soft_reset();
    int n;
    set_code(1);
    run_frame();
    for (int i = 0; i < 40; i++) begin
      mdc_tick = (i % 2 == 0);
      @(negedge clk);
    end
    mdc_tick = 1'b0;
    srst = 1'b1;
    @(negedge clk); srst = 1'b0;
    chk("R5 soft reset drops request", int'(poll_req), 0);
    chk("R5 soft reset keeps dwell code", int'(dwell_code), 1);
    @(negedge clk);
    chk("R5 polling restarts after soft reset", int'(poll_req), 1);
    run_frame();
    measure(n, -1, 0);
    chk("R5 full wait after soft reset", n, 128);
  endtask

  task automatic t_withdraw();
    int seen = 0;
    chk("R6 request pending before disable", int'(poll_req), 1);
    poll_en = 1'b0;
    @(negedge clk);
    chk("R6 disable withdraws request", int'(poll_req), 0);
    for (int i = 0; i < 20; i++) begin
      mdc_tick = (i % 2 == 0);
      @(negedge clk);
      if (poll_req) seen = 1;
    end
    mdc_tick = 1'b0;
    chk("R6 stays quiet while disabled", seen, 0);
    poll_en = 1'b1;
    @(negedge clk);
    chk("R10 request after re-enable", int'(poll_req), 1);
  endtask

  initial begin
    t_reset();
    t_disabled();
    t_enable();
    t_hold();
    t_default_wait();
    t_all_codes();
    t_write_mid();
    t_soft_reset();
    t_withdraw();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule